// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a two-wire (I2C) target that fronts a 256-byte on-chip memory. It watches the open-drain SCL and SDA lines through a two-flop synchronizer on the system clock. It recognises START, repeated START and STOP, and compares the 7-bit device address with the `DEV_ADDR` parameter. It answers only by pulling SDA low through `sda_pull_o`, and it never drives the line high.

An 8-bit address pointer holds its value from one transaction to the next. A read with no address phase returns the byte at the pointer. A write transaction first loads the pointer from the word-address byte and then stores any data bytes that follow. A random read is a write that stops after the word address, followed by a repeated START with the read bit set. Every byte that is transferred, read or written, advances the pointer by one, and the pointer wraps from 255 to 0. A read keeps going for as long as the master acknowledges each byte and ends at its first NACK.

The control is a single state machine with these states:

| State | What the target does |
|---|---|
| `ST_IDLE` | Waits for a START. |
| `ST_ADDR` | Shifts in the address byte. |
| `ST_ADDR_ACK` | Pulls SDA low to acknowledge a matching address. |
| `ST_WORD` | Shifts in the word-address byte. |
| `ST_WORD_ACK` | Acknowledges the word address. |
| `ST_WDATA` | Shifts in a write data byte. |
| `ST_WDATA_ACK` | Acknowledges a write data byte. |
| `ST_RDATA` | Shifts a read byte out. |
| `ST_RACK` | Samples the master's ACK or NACK. |
| `ST_HOLD` | Releases the bus and waits for the next START or STOP. |

Transitions:
- STOP takes any state to `ST_IDLE`.
- START or repeated START takes any state to `ST_ADDR`.
- The following transitions happen on the falling SCL edge:
  - `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches and to `ST_HOLD` when it does not.
  - `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_WORD` for a write.
  - `ST_WORD` goes to `ST_WORD_ACK`, which goes to `ST_WDATA`.
  - `ST_WDATA` and `ST_WDATA_ACK` alternate.
  - `ST_RDATA` goes to `ST_RACK` after the eighth bit.
  - `ST_RACK` goes back to `ST_RDATA` on ACK and to `ST_HOLD` on NACK.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset `sda_pull_o` is 0, the address pointer is 0 and every memory byte reads as 0x00.
- R2: An address byte is sent MSB first: the 7-bit device address, then the R/W bit, where 1 means read. When the device address equals `DEV_ADDR`, the target pulls SDA low during the ninth clock. When it differs, the target gives no ACK, drives nothing, and leaves pointer and memory unchanged until the next START.
- R3: In a write (R/W=0), the target acknowledges the word-address byte and loads it into the pointer. It then acknowledges each following data byte, stores it at the pointer and advances the pointer.
- R4: A random read returns the byte at the word address. It is made of a write that carries only the word address, then a repeated START and a read address byte.
- R5: A read without an address phase returns the byte one past the last location accessed. The first such read after reset returns location 0.
- R6: During a read, an ACK from the master makes the target send the byte at the next address. After a NACK the target releases SDA and drives nothing until START or STOP.
- R7: The pointer is 8 bits and wraps from 255 to 0 during both writes and sequential reads.
- R8: Data is shifted MSB first. `sda_pull_o` changes only while SCL is low, and a 1 on it means SDA is pulled low.
- R9: STOP returns the target to idle. START or repeated START restarts address reception from any state. The pointer keeps its value through both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Read accesses are tried in four patterns:
- a read with no address phase, straight after reset and after writes, which tells the persistent pointer apart from a pointer that restarts;
- a random read, which shows that the word address is loaded without writing data;
- a long acknowledged run past location 255, which shows the wrap and the per-byte increment;
- a repeated START in the middle of a write, which tells the restart of address reception apart from a data write.

Two patterns cover the cases where the target must stay off the bus:
- a foreign address, after which a read shows the pointer untouched;
- extra clocks after a NACK.

In both, SDA must stay released. The expected line level is compared on every clock while SCL is high, so a bit sent early, late or inverted is caught, not only a wrong byte.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_HOLD
    } tgt_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] chain [STAGES];
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '1;
                    else        chain[g] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= chain[STAGES-1];
    end

    logic scl_q, sda_q;

    assign scl_s     = chain[STAGES-1][1];
    assign sda_s     = chain[STAGES-1][0];
    assign scl_q     = prev[1];
    assign sda_q     = prev[0];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (wr_en) begin
            cells[addr] <= wr_data;
        end
    end

    assign rd_data = cells[addr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 8,
    parameter int         SYNC_STG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tgt_state_t          state, state_nx;
    logic [CNT_W-1:0]    bitcnt;
    logic                byte_rdy;
    logic [BYTE_W-1:0]   shreg, txreg, rd_data;
    logic [ADDR_W-1:0]   ptr;
    logic                rw_q, mack_q, pull_q, wr_en, addr_hit, rx_state;

    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign rx_state = (state == ST_ADDR) || (state == ST_WORD) || (state == ST_WDATA);
    assign wr_en    = scl_fall && (state == ST_WDATA) && byte_rdy;

    i2c_mem_store #(.AW(ADDR_W), .DW(BYTE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (shreg),
        .rd_data (rd_data)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_rdy) state_nx = addr_hit ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK:  state_nx = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:      if (byte_rdy) state_nx = ST_WORD_ACK;
                ST_WORD_ACK:  state_nx = ST_WDATA;
                ST_WDATA:     if (byte_rdy) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_WDATA;
                ST_RDATA:     if (bitcnt == LAST_BIT) state_nx = ST_RACK;
                ST_RACK:      state_nx = mack_q ? ST_RDATA : ST_HOLD;
                ST_HOLD:      state_nx = ST_HOLD;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath and line output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            byte_rdy <= 1'b0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            pull_q   <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt   <= '0;
            byte_rdy <= 1'b0;
            pull_q   <= 1'b0;
        end else begin
            if (scl_rise) begin
                if (rx_state) begin
                    shreg  <= {shreg[BYTE_W-2:0], sda_s};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) byte_rdy <= 1'b1;
                end
                if (state == ST_RACK) mack_q <= ~sda_s;
            end
            if (scl_fall) begin
                unique case (state)
                    ST_ADDR: if (byte_rdy) begin
                        byte_rdy <= 1'b0;
                        bitcnt   <= '0;
                        rw_q     <= shreg[0];
                        pull_q   <= addr_hit;
                    end
                    ST_ADDR_ACK: begin
                        bitcnt <= '0;
                        if (rw_q) begin
                            txreg  <= rd_data;
                            pull_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                    ST_WORD: if (byte_rdy) begin
                        byte_rdy <= 1'b0;
                        bitcnt   <= '0;
                        ptr      <= ADDR_W'(shreg);
                        pull_q   <= 1'b1;
                    end
                    ST_WDATA: if (byte_rdy) begin
                        byte_rdy <= 1'b0;
                        bitcnt   <= '0;
                        ptr      <= ptr + 1'b1;
                        pull_q   <= 1'b1;
                    end
                    ST_RDATA: begin
                        if (bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            ptr    <= ptr + 1'b1;
                            pull_q <= 1'b0;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            pull_q <= ~txreg[BYTE_W-2];
                        end
                    end
                    ST_RACK: begin
                        if (mack_q) begin
                            txreg  <= rd_data;
                            pull_q <= ~rd_data[BYTE_W-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                    default: pull_q <= 1'b0;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;

    // R8: line output moves only while the synchronized clock is low
    a_r8_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q != $past(pull_q)) |-> !scl_s);

    // R2: a matching address is acknowledged
    a_r2_ack_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> pull_q);

    // R2/R6: hold state keeps the line released
    a_r6_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !pull_q);

    // R7: each finished read byte advances the pointer by one, modulo depth
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK && $past(state) == ST_RDATA) |-> ptr == ADDR_W'($past(ptr) + 1'b1));

    // R9: STOP returns the machine to idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R5: a read byte is loaded from the memory at the pointer
    a_r5_read_load: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_ADDR_ACK && state == ST_RDATA) |-> txreg == $past(rd_data));
endmodule

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
    localparam int Q = 4;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_pull_o;
    logic sda_bus;
    logic exp_pull = 1'b0;
    logic mon_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int mem_m [256];
    int ptr_m = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = ~(m_low | sda_pull_o);

    i2c_mem_target #(.DEV_ADDR(DEV)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock model compare of the line level while SCL is high (R8)
    always @(negedge clk) begin
        if (mon_en && scl) begin
            checks++;
            if (sda_pull_o !== exp_pull) begin
                errors++;
                $display("FAIL R8 line model t=%0t actual=%0b expected=%0b", $time, sda_pull_o, exp_pull);
            end
        end
    end

    task automatic bus_start();
        exp_pull = 1'b0; m_low = 1'b0; scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_restart();
        exp_pull = 1'b0; m_low = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        exp_pull = 1'b0; m_low = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic got;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; exp_pull = 1'b0; tick(Q);
            scl = 1'b1; tick(2*Q);
            scl = 1'b0; tick(Q);
        end
        m_low = 1'b0; exp_pull = exp_ack; tick(Q);
        scl = 1'b1; tick(Q);
        got = ~sda_bus; tick(Q);
        scl = 1'b0; tick(Q);
        chk(got == exp_ack, tag, int'(got), int'(exp_ack));
    endtask

    task automatic recv_byte(input logic [7:0] e, input logic mack, input string tag);
        logic [7:0] d;
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            exp_pull = ~e[i]; tick(Q);
            scl = 1'b1; tick(Q);
            d[i] = sda_bus; tick(Q);
            scl = 1'b0; tick(Q);
        end
        exp_pull = 1'b0; m_low = mack; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
        m_low = 1'b0;
        chk(d == e, tag, int'(d), int'(e));
    endtask

    task automatic model_read(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            recv_byte(8'(mem_m[ptr_m]), (k != n-1), tag);
            ptr_m = (ptr_m + 1) % 256;
        end
    endtask

    task automatic write_txn(input logic [7:0] word, input int n, input int seed);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R2 addr write");
        send_byte(word, 1'b1, "R3 word ack");
        ptr_m = int'(word);
        for (int k = 0; k < n; k++) begin
            send_byte(8'((seed + 37*k) & 255), 1'b1, "R3 data ack");
            mem_m[ptr_m] = (seed + 37*k) & 255;
            ptr_m = (ptr_m + 1) % 256;
        end
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string tag);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, "R2 addr read");
        model_read(n, tag);
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] word, input int n, input string tag);
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R4 dummy write");
        send_byte(word, 1'b1, "R4 word ack");
        ptr_m = int'(word);
        bus_restart();
        send_byte({DEV, 1'b1}, 1'b1, "R4 read addr");
        model_read(n, tag);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 0;
        tick(5);
        chk(sda_pull_o == 1'b0, "R1 released in reset", int'(sda_pull_o), 0);
        rst_n = 1'b1;
        tick(5);
        chk(sda_pull_o == 1'b0, "R1 released after reset", int'(sda_pull_o), 0);
        mon_en = 1'b1;

        // R1/R5: first addressless read returns location 0, cleared
        cur_read(2, "R1 R5 read after reset");

        // R3/R7: write across the top of the array
        write_txn(8'hFD, 5, 8'hA1);

        // R4/R6/R7: random read across the wrap
        rand_read(8'hFE, 4, "R4 R6 R7 random seq");

        // R5: addressless read continues from the pointer
        cur_read(1, "R5 current address");

        // R2/R9: foreign address is ignored, no ACK, no drive
        bus_start();
        send_byte({7'h23, 1'b1}, 1'b0, "R2 foreign addr nack");
        recv_byte(8'hFF, 1'b0, "R2 foreign ignored");
        bus_stop();
        bus_start();
        send_byte({7'h23, 1'b0}, 1'b0, "R2 foreign write nack");
        send_byte(8'h10, 1'b0, "R2 foreign word ignored");
        bus_stop();
        cur_read(1, "R9 pointer kept after foreign");

        // R6: after NACK the target stays off the bus
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, "R2 addr read");
        model_read(1, "R6 single read");
        recv_byte(8'hFF, 1'b0, "R6 released after nack");
        bus_stop();

        // R9: repeated START in the middle of a write
        bus_start();
        send_byte({DEV, 1'b0}, 1'b1, "R9 addr write");
        send_byte(8'h40, 1'b1, "R9 word ack");
        ptr_m = 'h40;
        send_byte(8'h77, 1'b1, "R9 data ack");
        mem_m[ptr_m] = 'h77; ptr_m = ptr_m + 1;
        bus_restart();
        send_byte({DEV, 1'b1}, 1'b1, "R9 read after restart");
        model_read(1, "R9 read next after restart");
        bus_stop();
        rand_read(8'h40, 1, "R3 stored byte");

        // R7/R6: full sweep past 255
        write_txn(8'h80, 3, 8'h5C);
        rand_read(8'h02, 258, "R7 R6 full wrap");
        cur_read(1, "R7 R5 after wrap");

        mon_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(200000);
        errors++;
        $display("FAIL watchdog expired R9 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule